// File: doc/BRIEF.md
# VIPT L1 Data Cache Lookup

This block is the lookup stage of a 32KB, 8-way set-associative L1 data cache with 64-byte lines. The set index and the byte offset are both drawn from the low 12 bits of the virtual address, which lie inside the page offset of a 4KB page. The tag and data arrays can therefore be read while the TLB is still translating. The translated physical page number arrives one cycle after the request. It is compared against the stored physical tags of all eight ways of the selected set.

A load hit returns a 16-byte chunk taken from the line at the requested byte offset. A store hit merges 16 bytes into the line and marks it dirty. A miss stops the front end while the block handles it as one blocking operation. If the chosen victim way holds a dirty line, that line is first written back. The missing line is then requested, installed in the victim way, and any store data is merged into it. After a load miss the requester retries the load once the block is ready again. An access whose 16 bytes would run past the end of a line is refused with an error flag.

Top module: `vipt_lookup`

## Requirements
- R1: The set is selected by virtual address bits [11:6] (64 sets) and the byte within the 64-byte line by bits [5:0]. No other virtual address bits are used.
- R2: The physical page number on `tlb_ppn` is taken in the cycle after a request is accepted. It is compared with the tags of all 8 ways of the selected set. A hit needs a valid way whose tag is equal, and at most one way ever matches.
- R3: Exactly two clock edges after a request is accepted, `resp_valid` is high for one cycle, and exactly one of `resp_hit`, `resp_miss` and `resp_err` is high.
- R4: A load hit returns on `resp_data` the 16 bytes starting at byte offset VA[5:0], with line byte VA[5:0] in bits [7:0]. Unaligned offsets are allowed.
- R5: An access with VA[5:0] greater than 48 raises `resp_err`. It causes no miss, no fill request and no change of state, and `req_ready` stays high.
- R6: A store hit writes its 16 bytes at byte offset VA[5:0] into the line and marks the line dirty. Later loads return the merged bytes.
- R7: After a miss response, `req_ready` stays low until the line fill completes. `fill_req_valid` is held with `fill_addr` = {ppn, index} and a stable address until `fill_valid` is sampled high, together with the full line on `fill_data`.
- R8: A store that misses allocates the line. The fetched line is installed with the store bytes merged in and the dirty bit set.
- R9: If the victim way holds a valid dirty line, `wb_valid` is raised first, with `wb_addr` = {old tag, index} and the line on `wb_data`, and held until `wb_ack`. The fill request follows only after that. A clean or invalid victim produces no writeback.
- R10: The victim is the lowest-numbered invalid way. If all ways are valid, a 7-node binary tree pseudo-LRU chooses the victim. Every hit and every fill points each node on the accessed way's path away from that way. The victim is found by following the node bits from the root (0 = lower half, 1 = upper half).
- R11: After synchronous active-high reset, every line is invalid, `req_ready` is high, and `resp_valid`, `wb_valid` and `fill_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 12 | Page-offset bits of the virtual address |
| req_wdata | input | 128 | Store data, byte 0 in bits [7:0] |
| tlb_ppn | input | 24 | Translated physical page number, one cycle after the request |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Access hit |
| resp_miss | output | 1 | Access missed; miss handling started |
| resp_err | output | 1 | Chunk would cross the line boundary |
| resp_data | output | 128 | Load hit data |
| wb_valid | output | 1 | Dirty victim writeback request |
| wb_ack | input | 1 | Writeback accepted |
| wb_addr | output | 30 | Physical line address of the victim |
| wb_data | output | 512 | Victim line contents |
| fill_req_valid | output | 1 | Line fill request |
| fill_addr | output | 30 | Physical line address to fetch |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | 512 | Full line for the fill |

## Verification
Several properties are checked on every cycle. The assertions check that at most one way matches a tag, that each response has exactly one outcome flag, that a response follows each accepted request at fixed latency, and that the front end stays closed during a miss. They also check that the writeback and fill requests hold their addresses until they are acknowledged, and that a pseudo-LRU update never leaves the way just touched as the next victim. Other behaviour can only be shown by the bench's scenarios. These include the data returned for aligned and unaligned offsets, merged store bytes on hits and on allocating misses, and which line a full set evicts after a particular access history. They also include whether a writeback appears for dirty, clean and invalid victims, and that refused accesses leave the fill interface untouched.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int LINE_BYTES  = 64;
    localparam int NUM_WAYS    = 8;
    localparam int PAGE_BITS   = 12;
    localparam int CHUNK_BYTES = 16;
    localparam int PPN_W       = 24;

    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = PAGE_BITS - OFF_W;
    localparam int NUM_SETS = 1 << IDX_W;
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int CHUNK_W  = CHUNK_BYTES * 8;
    localparam int LADDR_W  = PPN_W + IDX_W;
    localparam int TREE_W   = NUM_WAYS - 1;
    localparam int MAX_OFF  = LINE_BYTES - CHUNK_BYTES;

    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [CHUNK_W-1:0] chunk_t;
    typedef logic [PPN_W-1:0]   ppn_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [WAY_W-1:0]   way_t;
    typedef logic [TREE_W-1:0]  tree_t;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_WRBACK,
        MS_FETCH
    } miss_state_e;

    typedef struct packed {
        logic                 write;
        logic [PAGE_BITS-1:0] vaddr;
        chunk_t               wdata;
    } access_t;

    typedef struct packed {
        idx_t   idx;
        ppn_t   ppn;
        ppn_t   old_tag;
        way_t   way;
        logic   write;
        off_t   off;
        chunk_t wdata;
    } miss_ctx_t;

    // Shift the line down so the requested byte lands at bit 0.
    function automatic chunk_t chunk_get(line_t l, off_t o);
        line_t s;
        s = l >> {o, 3'b000};
        return s[CHUNK_W-1:0];
    endfunction

    function automatic line_t chunk_put(line_t l, chunk_t c, off_t o);
        line_t m;
        line_t d;
        m = {{(LINE_W-CHUNK_W){1'b0}}, {CHUNK_W{1'b1}}} << {o, 3'b000};
        d = {{(LINE_W-CHUNK_W){1'b0}}, c} << {o, 3'b000};
        return (l & ~m) | d;
    endfunction

    function automatic logic off_crosses(off_t o);
        return int'(o) > MAX_OFF;
    endfunction

    // Heap-ordered tree: node n has children 2n+1 (lower) and 2n+2 (upper).
    function automatic way_t tree_victim(tree_t t);
        way_t w;
        int   node;
        w    = '0;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            w[WAY_W-1-lvl] = t[node];
            node = 2 * node + 1 + int'(t[node]);
        end
        return w;
    endfunction

    function automatic tree_t tree_touch(tree_t t, way_t w);
        tree_t r;
        int    node;
        r    = t;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            r[node] = ~w[WAY_W-1-lvl];
            node = 2 * node + 1 + int'(w[WAY_W-1-lvl]);
        end
        return r;
    endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  idx_t                rd_idx,
    input  ppn_t                cmp_ppn,
    input  way_t                sel_way,
    output logic [NUM_WAYS-1:0] hit_vec,
    output logic [NUM_WAYS-1:0] valid_vec,
    output logic [NUM_WAYS-1:0] dirty_vec,
    output ppn_t                sel_tag,
    input  logic                fill_en,
    input  idx_t                fill_idx,
    input  way_t                fill_way,
    input  ppn_t                fill_ppn,
    input  logic                fill_dirty,
    input  logic                mark_en,
    input  idx_t                mark_idx,
    input  way_t                mark_way
);

    ppn_t tag_rd [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        ppn_t                tags [NUM_SETS];
        logic [NUM_SETS-1:0] vld;
        logic [NUM_SETS-1:0] drt;
        logic                fill_here;
        logic                mark_here;

        assign fill_here = fill_en && (fill_way == way_t'(w));
        assign mark_here = mark_en && (mark_way == way_t'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= '0;
                drt <= '0;
            end else if (fill_here) begin
                vld[fill_idx] <= 1'b1;
                drt[fill_idx] <= fill_dirty;
            end else if (mark_here) begin
                drt[mark_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_here) begin
                tags[fill_idx] <= fill_ppn;
            end
        end

        assign tag_rd[w]    = tags[rd_idx];
        assign valid_vec[w] = vld[rd_idx];
        assign dirty_vec[w] = drt[rd_idx];
        assign hit_vec[w]   = vld[rd_idx] && (tags[rd_idx] == cmp_ppn);
    end

    assign sel_tag = tag_rd[sel_way];

    // R2: a physical tag lives in at most one way of a set
    p_single_match_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
    import vipt_pkg::*;
(
    input  logic  clk,
    input  idx_t  rd_idx,
    input  way_t  rd_way,
    output line_t rd_line,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  way_t  wr_way,
    input  line_t wr_line
);

    localparam int DEPTH = NUM_WAYS * NUM_SETS;

    line_t mem [DEPTH];

    assign rd_line = mem[{rd_way, rd_idx}];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_way, wr_idx}] <= wr_line;
        end
    end

endmodule

// File: rtl/vipt_plru.sv
module vipt_plru
    import vipt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    output way_t victim,
    input  logic touch_en,
    input  idx_t touch_idx,
    input  way_t touch_way
);

    tree_t trees [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                trees[s] <= '0;
            end
        end else if (touch_en) begin
            trees[touch_idx] <= tree_touch(trees[touch_idx], touch_way);
        end
    end

    assign victim = tree_victim(trees[rd_idx]);

    // R10: the way just used is never the next victim of its set
    p_touch_spares_way_r10: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (tree_victim(trees[$past(touch_idx)]) != $past(touch_way)));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [PAGE_BITS-1:0] req_vaddr,
    input  logic [CHUNK_W-1:0]   req_wdata,
    input  logic [PPN_W-1:0]     tlb_ppn,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic                 resp_miss,
    output logic                 resp_err,
    output logic [CHUNK_W-1:0]   resp_data,
    output logic                 wb_valid,
    input  logic                 wb_ack,
    output logic [LADDR_W-1:0]   wb_addr,
    output logic [LINE_W-1:0]    wb_data,
    output logic                 fill_req_valid,
    output logic [LADDR_W-1:0]   fill_addr,
    input  logic                 fill_valid,
    input  logic [LINE_W-1:0]    fill_data
);

    miss_state_e state_q;
    miss_ctx_t   miss_q;
    access_t     s1_q;
    logic        s1_v;

    logic [NUM_WAYS-1:0] hit_vec;
    logic [NUM_WAYS-1:0] valid_vec;
    logic [NUM_WAYS-1:0] dirty_vec;
    ppn_t                vict_tag;
    way_t                plru_way;
    way_t                vict_way;
    way_t                hit_way;
    line_t               rd_line;

    idx_t   s1_idx;
    off_t   s1_off;
    logic   s1_err;
    logic   s1_hit;
    logic   s1_miss;
    logic   accept;
    logic   fill_done;

    idx_t   data_rd_idx;
    way_t   data_rd_way;
    logic   data_wr_en;
    idx_t   data_wr_idx;
    way_t   data_wr_way;
    line_t  data_wr_line;

    logic   touch_en;
    idx_t   touch_idx;
    way_t   touch_way;

    // ---------------- stage 1 decode ----------------
    assign s1_idx  = s1_q.vaddr[PAGE_BITS-1:OFF_W];
    assign s1_off  = s1_q.vaddr[OFF_W-1:0];
    assign s1_err  = off_crosses(s1_off);
    assign s1_hit  = s1_v && !s1_err && (|hit_vec);
    assign s1_miss = s1_v && !s1_err && !(|hit_vec);

    assign req_ready = (state_q == MS_IDLE) && !s1_miss;
    assign accept    = req_valid && req_ready;
    assign fill_done = (state_q == MS_FETCH) && fill_valid;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = way_t'(w);
            end
        end
    end

    // Lowest invalid way wins; otherwise the tree choice.
    always_comb begin
        vict_way = plru_way;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                vict_way = way_t'(w);
            end
        end
    end

    // ---------------- arrays ----------------
    vipt_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .rd_idx     (s1_idx),
        .cmp_ppn    (tlb_ppn),
        .sel_way    (vict_way),
        .hit_vec    (hit_vec),
        .valid_vec  (valid_vec),
        .dirty_vec  (dirty_vec),
        .sel_tag    (vict_tag),
        .fill_en    (fill_done),
        .fill_idx   (miss_q.idx),
        .fill_way   (miss_q.way),
        .fill_ppn   (miss_q.ppn),
        .fill_dirty (miss_q.write),
        .mark_en    (s1_hit && s1_q.write),
        .mark_idx   (s1_idx),
        .mark_way   (hit_way)
    );

    assign data_rd_idx = (state_q == MS_IDLE) ? s1_idx  : miss_q.idx;
    assign data_rd_way = (state_q == MS_IDLE) ? hit_way : miss_q.way;

    always_comb begin
        data_wr_en   = 1'b0;
        data_wr_idx  = s1_idx;
        data_wr_way  = hit_way;
        data_wr_line = chunk_put(rd_line, s1_q.wdata, s1_off);
        if (fill_done) begin
            data_wr_en   = 1'b1;
            data_wr_idx  = miss_q.idx;
            data_wr_way  = miss_q.way;
            data_wr_line = miss_q.write ? chunk_put(fill_data, miss_q.wdata, miss_q.off)
                                        : fill_data;
        end else if (s1_hit && s1_q.write) begin
            data_wr_en   = 1'b1;
        end
    end

    vipt_data_store u_data (
        .clk     (clk),
        .rd_idx  (data_rd_idx),
        .rd_way  (data_rd_way),
        .rd_line (rd_line),
        .wr_en   (data_wr_en),
        .wr_idx  (data_wr_idx),
        .wr_way  (data_wr_way),
        .wr_line (data_wr_line)
    );

    assign touch_en  = s1_hit || fill_done;
    assign touch_idx = fill_done ? miss_q.idx : s1_idx;
    assign touch_way = fill_done ? miss_q.way : hit_way;

    vipt_plru u_plru (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (s1_idx),
        .victim    (plru_way),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_way (touch_way)
    );

    // ---------------- pipeline and miss control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_q <= '0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_q <= '{write: req_write, vaddr: req_vaddr, wdata: req_wdata};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            resp_err   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= s1_v;
            resp_hit   <= s1_hit;
            resp_miss  <= s1_miss;
            resp_err   <= s1_v && s1_err;
            resp_data  <= (s1_hit && !s1_q.write) ? chunk_get(rd_line, s1_off) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MS_IDLE;
            miss_q  <= '0;
        end else begin
            case (state_q)
                MS_IDLE: begin
                    if (s1_miss) begin
                        miss_q <= '{idx: s1_idx, ppn: tlb_ppn, old_tag: vict_tag,
                                    way: vict_way, write: s1_q.write, off: s1_off,
                                    wdata: s1_q.wdata};
                        state_q <= (valid_vec[vict_way] && dirty_vec[vict_way])
                                   ? MS_WRBACK : MS_FETCH;
                    end
                end
                MS_WRBACK: begin
                    if (wb_ack) begin
                        state_q <= MS_FETCH;
                    end
                end
                MS_FETCH: begin
                    if (fill_valid) begin
                        state_q <= MS_IDLE;
                    end
                end
                default: state_q <= MS_IDLE;
            endcase
        end
    end

    assign wb_valid       = (state_q == MS_WRBACK);
    assign wb_addr        = {miss_q.old_tag, miss_q.idx};
    assign wb_data        = rd_line;
    assign fill_req_valid = (state_q == MS_FETCH);
    assign fill_addr      = {miss_q.ppn, miss_q.idx};

    // ---------------- assertions ----------------
    // R3: one outcome per response
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($countones({resp_hit, resp_miss, resp_err}) == 1));

    // R3: fixed two-edge latency from acceptance to response
    p_resp_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> ##2 resp_valid);

    // R7: a miss response closes the front end
    p_miss_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        resp_miss |-> !req_ready);

    // R7: fill request and address held until data arrives
    p_fill_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_req_valid && !fill_valid) |=> (fill_req_valid && $stable(fill_addr)));

    // R9: writeback request and address held until acknowledged
    p_wb_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_addr)));

    // R9: an acknowledged writeback is followed by the fill request
    p_wb_then_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_ack) |=> fill_req_valid);

endmodule

// File: tb/sim_vipt_lookup.sv
module sim_vipt_lookup;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;
    localparam logic [1:0] EX_HIT = 2'd0;
    localparam logic [1:0] EX_MISS = 2'd1;
    localparam logic [1:0] EX_ERR = 2'd2;

    // {vaddr[11:0], ppn[23:0], expected outcome[1:0]}, all loads
    localparam logic [37:0] VEC [NV] = '{
        {12'h0C0, 24'h000010, EX_HIT},
        {12'h0C5, 24'h000010, EX_HIT},
        {12'h0F0, 24'h000010, EX_HIT},
        {12'h0F1, 24'h000010, EX_ERR},
        {12'h0C0, 24'h000011, EX_MISS},
        {12'h0C0, 24'h000010, EX_HIT},
        {12'h0C0, 24'h000011, EX_HIT},
        {12'h100, 24'h000010, EX_MISS},
        {12'h10B, 24'h000010, EX_HIT},
        {12'hFFF, 24'h000010, EX_ERR},
        {12'hFC0, 24'h000010, EX_MISS},
        {12'hFF0, 24'h000010, EX_HIT},
        {12'h0E7, 24'h000011, EX_HIT}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [11:0] req_vaddr = '0;
    logic [127:0] req_wdata = '0;
    logic [23:0] tlb_ppn = '0;
    logic resp_valid, resp_hit, resp_miss, resp_err;
    logic [127:0] resp_data;
    logic wb_valid;
    logic wb_ack = 1'b0;
    logic [29:0] wb_addr;
    logic [511:0] wb_data;
    logic fill_req_valid;
    logic [29:0] fill_addr;
    logic fill_valid = 1'b0;
    logic [511:0] fill_data = '0;

    int checks = 0;
    int errors = 0;
    int wb_cnt = 0;
    int fill_cnt = 0;
    int overlap = 0;
    logic [29:0] last_wb_addr = '0;
    logic [511:0] last_wb_data = '0;
    logic [29:0] last_fill_addr = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vipt_lookup u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_vaddr(req_vaddr), .req_wdata(req_wdata), .tlb_ppn(tlb_ppn),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_err(resp_err), .resp_data(resp_data),
        .wb_valid(wb_valid), .wb_ack(wb_ack), .wb_addr(wb_addr), .wb_data(wb_data),
        .fill_req_valid(fill_req_valid), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [511:0] linepat(logic [29:0] la);
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = {la[27:0], 4'(i)};
        return r;
    endfunction

    function automatic logic [127:0] exp_chunk(logic [511:0] l, int off);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[8*b +: 8] = l[8*(off+b) +: 8];
        return r;
    endfunction

    function automatic logic [511:0] exp_put(logic [511:0] l, logic [127:0] c, int off);
        logic [511:0] r;
        r = l;
        for (int b = 0; b < 16; b++) r[8*(off+b) +: 8] = c[8*b +: 8];
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_access(input logic wr, input logic [11:0] va, input logic [23:0] ppn,
                             input logic [127:0] wd, output logic h, output logic m,
                             output logic e, output logic [127:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tlb_ppn = ppn;
        @(negedge clk);
        check_vec("R3 resp_valid two edges after accept", 512'(resp_valid), 512'(1));
        check_vec("R3 single outcome flag",
                  512'($countones({resp_hit, resp_miss, resp_err})), 512'(1));
        h = resp_hit; m = resp_miss; e = resp_err; d = resp_data;
    endtask

    // Lower-level memory model: acknowledges writebacks, answers fills.
    initial begin
        forever begin
            @(negedge clk);
            if (wb_valid) begin
                wb_cnt++;
                last_wb_addr = wb_addr;
                last_wb_data = wb_data;
                if (fill_req_valid) overlap++;
                repeat (2) @(negedge clk);
                wb_ack = 1'b1;
                @(negedge clk);
                wb_ack = 1'b0;
            end else if (fill_req_valid) begin
                fill_cnt++;
                last_fill_addr = fill_addr;
                repeat (2) @(negedge clk);
                fill_valid = 1'b1;
                fill_data = linepat(fill_addr);
                @(negedge clk);
                fill_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic h, m, e;
        logic [127:0] d;
        logic [511:0] shadow;
        logic [127:0] w1, w2, w3;
        int wb0, fb0;

        w1 = 128'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D4;
        w2 = 128'h5566_7788_99AA_BBCC_DDEE_FF00_1122_3344;
        w3 = 128'h0123_4567_89AB_CDEF_0011_2233_4455_6600;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check_vec("R11 req_ready after reset", 512'(req_ready), 512'(1));
        check_vec("R11 resp_valid after reset", 512'(resp_valid), 512'(0));
        check_vec("R11 wb_valid after reset", 512'(wb_valid), 512'(0));
        check_vec("R11 fill_req_valid after reset", 512'(fill_req_valid), 512'(0));

        // R11: every line invalid, so the first access misses
        do_access(1'b0, 12'h0C0, 24'h10, '0, h, m, e, d);
        check_vec("R11 first access misses", 512'(m), 512'(1));
        // R7: front end closed, fill requested with {ppn, index}
        check_vec("R7 req_ready low after miss", 512'(req_ready), 512'(0));
        wait_idle();
        check_vec("R7 fill address", 512'(last_fill_addr), 512'({24'h10, 6'd3}));

        // Table walk: R1/R2 lookup, R4 data, R5 errors
        for (int i = 0; i < NV; i++) begin
            logic [11:0] va;
            logic [23:0] ppn;
            logic [1:0] ex;
            int fb;
            va = VEC[i][37:26];
            ppn = VEC[i][25:2];
            ex = VEC[i][1:0];
            fb = fill_cnt;
            do_access(1'b0, va, ppn, '0, h, m, e, d);
            check_vec("R1/R2 hit flag", 512'(h), 512'(ex == EX_HIT));
            check_vec("R1/R2 miss flag", 512'(m), 512'(ex == EX_MISS));
            check_vec("R5 err flag", 512'(e), 512'(ex == EX_ERR));
            if (ex == EX_HIT)
                check_vec("R4 load chunk", 512'(d),
                          512'(exp_chunk(linepat({ppn, va[11:6]}), int'(va[5:0]))));
            if (ex == EX_MISS) begin
                wait_idle();
                check_vec("R7 fill address", 512'(last_fill_addr), 512'({ppn, va[11:6]}));
            end
            if (ex == EX_ERR) begin
                repeat (4) @(negedge clk);
                check_vec("R5 no fill after err", 512'(fill_cnt), 512'(fb));
                check_vec("R5 ready after err", 512'(req_ready), 512'(1));
            end
        end

        // R6: store hit merges bytes at an unaligned offset
        do_access(1'b1, 12'h0C4, 24'h10, w1, h, m, e, d);
        check_vec("R6 store hit", 512'(h), 512'(1));
        shadow = exp_put(linepat({24'h10, 6'd3}), w1, 4);
        do_access(1'b0, 12'h0C4, 24'h10, '0, h, m, e, d);
        check_vec("R6 reload stored chunk", 512'(d), 512'(w1));
        do_access(1'b0, 12'h0C0, 24'h10, '0, h, m, e, d);
        check_vec("R6 merged neighbour bytes", 512'(d), 512'(exp_chunk(shadow, 0)));

        // R8: store miss allocates and merges
        do_access(1'b1, 12'h208, 24'h20, w2, h, m, e, d);
        check_vec("R8 store miss", 512'(m), 512'(1));
        check_vec("R7 ready low on store miss", 512'(req_ready), 512'(0));
        wait_idle();
        shadow = exp_put(linepat({24'h20, 6'd8}), w2, 8);
        do_access(1'b0, 12'h208, 24'h20, '0, h, m, e, d);
        check_vec("R8 allocated store data", 512'(d), 512'(w2));
        do_access(1'b0, 12'h200, 24'h20, '0, h, m, e, d);
        check_vec("R8 allocated line merge", 512'(d), 512'(exp_chunk(shadow, 0)));

        // R10/R9: fill set 10 with dirty lines, touch way 0, force eviction
        wb0 = wb_cnt;
        for (int k = 0; k < 8; k++) begin
            do_access(1'b1, 12'h280, 24'h31 + 24'(k), w3 + 128'(k), h, m, e, d);
            check_vec("R10 fill into invalid way", 512'(m), 512'(1));
            wait_idle();
        end
        check_vec("R9 no writeback for invalid victims", 512'(wb_cnt), 512'(wb0));
        do_access(1'b0, 12'h280, 24'h31, '0, h, m, e, d);
        check_vec("R10 hit oldest line", 512'(d), 512'(w3));
        fb0 = fill_cnt;
        do_access(1'b0, 12'h280, 24'h39, '0, h, m, e, d);
        check_vec("R10 miss in full set", 512'(m), 512'(1));
        wait_idle();
        check_vec("R9 one writeback", 512'(wb_cnt), 512'(wb0 + 1));
        check_vec("R10 tree victim address", 512'(last_wb_addr), 512'({24'h35, 6'd10}));
        check_vec("R9 writeback data", last_wb_data,
                  exp_put(linepat({24'h35, 6'd10}), w3 + 128'd4, 0));
        check_vec("R9 fill not during writeback", 512'(overlap), 512'(0));
        check_vec("R9 fill after writeback", 512'(fill_cnt), 512'(fb0 + 1));
        do_access(1'b0, 12'h280, 24'h32, '0, h, m, e, d);
        check_vec("R10 second-oldest kept", 512'(h), 512'(1));
        do_access(1'b0, 12'h280, 24'h39, '0, h, m, e, d);
        check_vec("R10 new line present", 512'(h), 512'(1));

        // R9: clean victim in a full set, no writeback
        for (int k = 0; k < 8; k++) begin
            do_access(1'b0, 12'h500, 24'h41 + 24'(k), '0, h, m, e, d);
            wait_idle();
        end
        wb0 = wb_cnt;
        fb0 = fill_cnt;
        do_access(1'b0, 12'h500, 24'h49, '0, h, m, e, d);
        check_vec("R9 clean victim miss", 512'(m), 512'(1));
        wait_idle();
        check_vec("R9 no writeback for clean victim", 512'(wb_cnt), 512'(wb0));
        check_vec("R9 clean victim fill", 512'(fill_cnt), 512'(fb0 + 1));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule